// File: doc/BRIEF.md
# Paired Stream Combining Router

This block sits after a bank of six channel filters. Each filter delivers a signed 22-bit I/Q word with a valid strobe. The block can merge neighbouring channels in fixed pairs (0 with 1, 2 with 3, 4 with 5). A 3-bit mode word chooses two things: the kind of merge and how many pairs, counted from pair 0, take part.

There are two kinds of merge:

- **Biphase.** The filtered even-phase stream (the lower channel) is added to the odd-phase stream (the upper channel). Two half-rate filters then act as one filter running at twice the rate.
- **Complex.** Two real-filter channels are folded into one complex result.

A merged result is written to the lower slot of its pair, and the upper slot goes silent. Pairs that are not merged pass both streams through unchanged. Every output is registered, so outputs follow the inputs by one clock.

Sums are formed one bit wider and then saturated back to 22 bits. Any saturation sets a sticky overflow flag. The mode word is taken in only on cycles where no input is valid, so a pairing never changes in the middle of a sample.

Top module: `pair_combine_router`

## Requirements
- R1: After reset every out_valid bit is 0, ovf_sticky is 0 and the captured mode is 000 (all streams pass through).
- R2: For any unmerged pair, each stream s passes through with one clock of latency: out_valid[s], out_i[s] and out_q[s] equal the cycle-earlier in_valid[s], in_i[s] and in_q[s]. Modes 000 and 100 leave every pair unmerged.
- R3: The mode bits [1:0] give the count n of merged pairs; pairs 0 to n-1 are merged. Bit 2 selects the merge kind: 1 = biphase, 0 = complex. Example codes: 001/010/011 are complex with 1/2/3 pairs, and 101/110/111 are biphase with 1/2/3 pairs.
- R4: A biphase merged output is I = I_low + I_high and Q = Q_low + Q_high.
- R5: A complex merged output is I = I_low − Q_high and Q = Q_low + I_high.
- R6: Every merged sum is saturated to the signed 22-bit range [−2097152, 2097151].
- R7: ovf_sticky rises one clock after a cycle in which a valid merged sum saturated. It then stays 1 until reset.
- R8: In a merged pair, the upper slot's out_valid is always 0. The lower slot's out_valid is 1 only when both members were valid in the same input cycle.
- R9: The mode word is captured at a clock edge only if no in_valid bit is 1 in that cycle. It applies to samples from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Pairing mode word |
| in_i | input | 6x22 | In-phase input per stream, signed |
| in_q | input | 6x22 | Quadrature input per stream, signed |
| in_valid | input | 6 | Valid strobe per input stream |
| out_i | output | 6x22 | In-phase output per slot |
| out_q | output | 6x22 | Quadrature output per slot |
| out_valid | output | 6 | Live flag per output slot |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
Random data is driven under random valid masks in every mode code, including the reserved code. Partial masks show whether a lower slot waits for its partner. Mixed pair counts show whether the unmerged pairs really pass through untouched.

Directed extreme values are then driven:

- maximum plus maximum in biphase mode, which separates correct saturation from wrap-around;
- minimum minus maximum in complex mode, which exposes a swapped I/Q term or a wrong sign.

A mode change presented while traffic is valid, followed by an idle cycle, separates correct capture timing from capture on every cycle.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_CPLX = 2'd1,
    CK_BIPH = 2'd2
  } comb_kind_e;
endpackage

// File: rtl/pcr_mode_ctrl.sv
module pcr_mode_ctrl
  import pcr_pkg::*;
#(
  parameter int unsigned NPAIR  = 3,
  parameter int unsigned MODE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    any_valid,
  output logic [MODE_W-1:0]       mode_q,
  output comb_kind_e [NPAIR-1:0]  pair_kind
);
  localparam int unsigned CNT_W = MODE_W - 1;

  logic [CNT_W-1:0] pair_cnt;
  logic             biphase_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= '0;
    else if (!any_valid) mode_q <= mode_i;
  end

  assign pair_cnt    = mode_q[CNT_W-1:0];
  assign biphase_sel = mode_q[MODE_W-1];

  for (genvar p = 0; p < NPAIR; p++) begin : g_kind
    always_comb begin
      if (32'(p) < 32'(pair_cnt))
        pair_kind[p] = biphase_sel ? CK_BIPH : CK_CPLX;
      else
        pair_kind[p] = CK_NONE;
    end
  end
endmodule

// File: rtl/pcr_pair_unit.sv
module pcr_pair_unit
  import pcr_pkg::*;
#(
  parameter int unsigned DW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  comb_kind_e    kind,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] lo_q,
  input  logic          lo_v,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] hi_q,
  input  logic          hi_v,
  output logic [DW-1:0] o_lo_i,
  output logic [DW-1:0] o_lo_q,
  output logic          o_lo_v,
  output logic [DW-1:0] o_hi_i,
  output logic [DW-1:0] o_hi_q,
  output logic          o_hi_v,
  output logic          sat_evt
);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  // Widened add or subtract of two signed words.
  function automatic logic [DW:0] wide_op(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic sub);
    logic [DW:0] ea, eb;
    ea = {a[DW-1], a};
    eb = {b[DW-1], b};
    return sub ? (ea - eb) : (ea + eb);
  endfunction

  function automatic logic wide_ovf(input logic [DW:0] s);
    return s[DW] ^ s[DW-1];
  endfunction

  function automatic logic [DW-1:0] clamp(input logic [DW:0] s);
    if (!wide_ovf(s)) return s[DW-1:0];
    return s[DW] ? NEG_MIN : POS_MAX;
  endfunction

  logic [DW:0]   sum_i, sum_q;
  logic          merging, both_v;
  logic [DW-1:0] res_i, res_q;

  always_comb begin
    if (kind == CK_CPLX) begin
      sum_i = wide_op(lo_i, hi_q, 1'b1);
      sum_q = wide_op(lo_q, hi_i, 1'b0);
    end else begin
      sum_i = wide_op(lo_i, hi_i, 1'b0);
      sum_q = wide_op(lo_q, hi_q, 1'b0);
    end
  end

  assign merging = (kind != CK_NONE);
  assign both_v  = lo_v & hi_v;
  assign res_i   = clamp(sum_i);
  assign res_q   = clamp(sum_q);
  assign sat_evt = merging & both_v & (wide_ovf(sum_i) | wide_ovf(sum_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_lo_i <= '0; o_lo_q <= '0; o_lo_v <= 1'b0;
      o_hi_i <= '0; o_hi_q <= '0; o_hi_v <= 1'b0;
    end else begin
      o_hi_i <= hi_i;
      o_hi_q <= hi_q;
      if (merging) begin
        o_lo_i <= res_i;
        o_lo_q <= res_q;
        o_lo_v <= both_v;
        o_hi_v <= 1'b0;
      end else begin
        o_lo_i <= lo_i;
        o_lo_q <= lo_q;
        o_lo_v <= lo_v;
        o_hi_v <= hi_v;
      end
    end
  end
endmodule

// File: rtl/pair_combine_router.sv
module pair_combine_router
  import pcr_pkg::*;
#(
  parameter int unsigned NPAIR  = 3,
  parameter int unsigned DW     = 22,
  parameter int unsigned MODE_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MODE_W-1:0]             mode_i,
  input  logic [2*NPAIR-1:0][DW-1:0]    in_i,
  input  logic [2*NPAIR-1:0][DW-1:0]    in_q,
  input  logic [2*NPAIR-1:0]            in_valid,
  output logic [2*NPAIR-1:0][DW-1:0]    out_i,
  output logic [2*NPAIR-1:0][DW-1:0]    out_q,
  output logic [2*NPAIR-1:0]            out_valid,
  output logic                          ovf_sticky
);
  localparam int unsigned NSTREAM = 2 * NPAIR;

  logic [MODE_W-1:0]      mode_q_w;
  comb_kind_e [NPAIR-1:0] kind_w;
  logic [NPAIR-1:0]       pair_on_w;
  logic [NPAIR-1:0]       sat_evt_w;

  pcr_mode_ctrl #(.NPAIR(NPAIR), .MODE_W(MODE_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .any_valid (|in_valid),
    .mode_q    (mode_q_w),
    .pair_kind (kind_w)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_on_w[p] = (kind_w[p] != CK_NONE);
    pcr_pair_unit #(.DW(DW)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind_w[p]),
      .lo_i    (in_i[2*p]),
      .lo_q    (in_q[2*p]),
      .lo_v    (in_valid[2*p]),
      .hi_i    (in_i[2*p+1]),
      .hi_q    (in_q[2*p+1]),
      .hi_v    (in_valid[2*p+1]),
      .o_lo_i  (out_i[2*p]),
      .o_lo_q  (out_q[2*p]),
      .o_lo_v  (out_valid[2*p]),
      .o_hi_i  (out_i[2*p+1]),
      .o_hi_q  (out_q[2*p+1]),
      .o_hi_v  (out_valid[2*p+1]),
      .sat_evt (sat_evt_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_sticky <= 1'b0;
    else        ovf_sticky <= ovf_sticky | (|sat_evt_w);
  end

  if (NSTREAM < 2) begin : g_bad
    initial $error("NPAIR must be at least 1");
  end
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
  parameter int unsigned NPAIR  = 3,
  parameter int unsigned MODE_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2*NPAIR-1:0]      in_valid,
  input logic [2*NPAIR-1:0]      out_valid,
  input logic                    ovf_sticky,
  input logic [MODE_W-1:0]       mode_q_w,
  input logic [NPAIR-1:0]        pair_on_w,
  input logic [NPAIR-1:0]        sat_evt_w
);
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);

  assert_sticky_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_sticky && |sat_evt_w) |=> ovf_sticky);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_valid) |=> $stable(mode_q_w));

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    assert_hi_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pair_on_w[p] |=> !out_valid[2*p+1]);

    assert_lo_needs_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_on_w[p] && !(in_valid[2*p] && in_valid[2*p+1])) |=> !out_valid[2*p]);

    assert_pass_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_on_w[p] |=> (out_valid[2*p+1:2*p] == $past(in_valid[2*p+1:2*p])));
  end
endmodule

bind pair_combine_router pcr_checker #(.NPAIR(NPAIR), .MODE_W(MODE_W)) u_pcr_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .ovf_sticky (ovf_sticky),
  .mode_q_w   (mode_q_w),
  .pair_on_w  (pair_on_w),
  .sat_evt_w  (sat_evt_w)
);

// File: tb/test_pair_combine_router.sv
module test_pair_combine_router;
  localparam int NS = 6;
  localparam int MAXV = 2097151;
  localparam int MINV = -2097152;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [NS-1:0][21:0] in_i = '0, in_q = '0;
  logic [NS-1:0] in_valid = '0;
  logic [NS-1:0][21:0] out_i, out_q;
  logic [NS-1:0] out_valid;
  logic ovf_sticky;

  int n_cmp = 0, n_bad = 0;
  int mode_m = 0;
  bit ovf_m = 0;
  string tag = "R2";
  int ev_i [NS], ev_q [NS];
  bit ev_v [NS];
  string tg_v [NS], tg_d [NS];

  always #5 clk = ~clk;

  pair_combine_router i_pair_combine_router (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_i(in_i), .in_q(in_q),
    .in_valid(in_valid), .out_i(out_i), .out_q(out_q), .out_valid(out_valid),
    .ovf_sticky(ovf_sticky));

  function automatic int sx(logic [21:0] v);
    return v[21] ? int'(v) - 4194304 : int'(v);
  endfunction

  function automatic int lim(int x, ref bit hit);
    if (x > MAXV) begin hit = 1; return MAXV; end
    if (x < MINV) begin hit = 1; return MINV; end
    return x;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: compute what the next edge should produce.
  task automatic predict();
    int npairs = mode_m % 4;
    bit biph = (mode_m >= 4);
    bit hit;
    for (int p = 0; p < NS/2; p++) begin
      int li = sx(in_i[2*p]), lq = sx(in_q[2*p]);
      int hi = sx(in_i[2*p+1]), hq = sx(in_q[2*p+1]);
      if (p < npairs) begin
        hit = 0;
        ev_v[2*p] = in_valid[2*p] && in_valid[2*p+1];
        ev_v[2*p+1] = 0;
        if (biph) begin
          ev_i[2*p] = lim(li + hi, hit);
          ev_q[2*p] = lim(lq + hq, hit);
        end else begin
          ev_i[2*p] = lim(li - hq, hit);
          ev_q[2*p] = lim(lq + hi, hit);
        end
        if (hit && ev_v[2*p]) ovf_m = 1;
        tg_v[2*p] = {"R8,", tag}; tg_v[2*p+1] = {"R8,", tag};
        tg_d[2*p] = biph ? {"R4,R6,", tag} : {"R5,R6,", tag};
      end else begin
        for (int k = 0; k < 2; k++) begin
          ev_v[2*p+k] = in_valid[2*p+k];
          ev_i[2*p+k] = sx(in_i[2*p+k]);
          ev_q[2*p+k] = sx(in_q[2*p+k]);
          tg_v[2*p+k] = {"R2,", tag};
          tg_d[2*p+k] = {"R2,", tag};
        end
      end
    end
    if (in_valid == '0) mode_m = int'(mode_i);
  endtask

  task automatic step();
    @(posedge clk);
    predict();
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      check(tg_v[s], int'(out_valid[s]), int'(ev_v[s]));
      if (ev_v[s]) begin
        check(tg_d[s], sx(out_i[s]), ev_i[s]);
        check(tg_d[s], sx(out_q[s]), ev_q[s]);
      end
    end
    check("R7", int'(ovf_sticky), int'(ovf_m));
  endtask

  task automatic rand_data(logic [NS-1:0] mask);
    for (int s = 0; s < NS; s++) begin
      in_i[s] = 22'($urandom);
      in_q[s] = 22'($urandom);
    end
    in_valid = mask;
  endtask

  task automatic set_mode(int m);
    in_valid = '0;
    mode_i = 3'(m);
    step();
  endtask

  task automatic do_reset();
    rst_n = 0;
    in_valid = '0;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(ovf_sticky), 0);
    rst_n = 1;
    mode_m = 0;
    ovf_m = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int codes [6] = '{1, 2, 3, 5, 6, 7};
    @(negedge clk);
    do_reset();
    // R1: with mode left at reset value, traffic must pass through.
    mode_i = 3'd7;
    tag = "R1";
    rand_data(6'h3F); step();
    tag = "R2";
    mode_i = 3'd0;
    set_mode(0);
    repeat (20) begin rand_data(6'($urandom)); step(); end
    set_mode(4);
    repeat (10) begin rand_data(6'($urandom)); step(); end
    tag = "R3";
    foreach (codes[c]) begin
      set_mode(codes[c]);
      repeat (12) begin
        rand_data(($urandom % 2) ? 6'h3F : 6'($urandom));
        step();
      end
    end
    // R9: mode change while busy is ignored, taken on the first idle cycle.
    tag = "R9";
    set_mode(5);
    mode_i = 3'd3;
    repeat (4) begin rand_data(6'h3F); step(); end
    in_valid = '0; step();
    repeat (4) begin rand_data(6'h3F); step(); end
    // R6/R7: biphase overflow toward the positive limit.
    tag = "R6";
    set_mode(7);
    in_valid = 6'h3F;
    in_i = '0; in_q = '0;
    in_i[0] = 22'(MAXV); in_i[1] = 22'(MAXV);
    in_q[0] = 22'(MINV); in_q[1] = 22'(MINV);
    step();
    // Complex negative limit: low I minimum minus high Q maximum.
    set_mode(1);
    in_valid = 6'h03;
    in_i = '0; in_q = '0;
    in_i[0] = 22'(MINV); in_q[1] = 22'(MAXV);
    in_q[0] = 22'(MAXV); in_i[1] = 22'(MAXV);
    step();
    // R7: flag remains set under quiet traffic until reset.
    tag = "R7";
    repeat (6) begin
      rand_data(6'h3F);
      for (int s = 0; s < NS; s++) begin in_i[s] = 22'(s); in_q[s] = 22'(s); end
      step();
    end
    check("R7", int'(ovf_sticky), 1);
    do_reset();
    tag = "R1";
    rand_data(6'h2A); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule